// File: doc/BRIEF.md
# Serial Target Front End with Transfer Pause

This block is the bit-level front end of a serial memory target. It shifts command and data bytes in from the master's data line and shifts response bytes out on the target's data line, under control of the serial clock and an active-low select. The master may park the serial clock low or high while idle (SPI modes 0 and 3). Both are accepted without configuration. Incoming bits are taken on each rising serial clock edge, and the outgoing line moves after each falling edge. Bytes travel most significant bit first.

An active-low pause input (`holdN`) freezes a transfer, even in the middle of a byte. While frozen, the bit position and both shift registers keep their values, clock and data toggles are ignored, and the output is released to high impedance (`soOe` low). The pause begins or ends only while the serial clock is low. A pause edge that arrives during the clock's high phase takes effect at the next low phase. Releasing select during a pause abandons the transfer.

All serial inputs are brought into a system clock domain through two-flop synchronizers. The system clock must run at least four times the serial clock rate, and eight times or more is recommended. The user side receives a one-cycle strobe with each complete byte. It supplies the next outgoing byte when asked.

Top module: `spi_hold_target`

## Requirements
- R1: In both idle polarities of the serial clock, the data line is sampled on each rising edge, MSB first. After the eighth sample, `rxData` holds the byte and `rxValid` is high for exactly one system cycle.
- R2: When select is asserted, `soData` shows bit 7 of `txData`. On each later falling edge that follows a rising edge, the next lower bit is shown. A falling edge that comes before any rising edge, which happens at the start in the high-idle mode, leaves `soData` unchanged.
- R3: `txReady` pulses once per completed byte, in the same cycle as `rxValid`. The value on `txData` at the next falling edge becomes the next outgoing byte.
- R4: While select is high, `soOe` is 0 and the bit position is cleared. A byte cut short by select going high produces no `rxValid`, and the next transfer starts at bit 7.
- R5: When `holdN` is low, select is low and the serial clock is low, the block enters the pause and `soOe` goes to 0.
- R6: If `holdN` falls while the serial clock is high, `soOe` stays 1. The pause begins at the next falling edge, and that edge still shifts the output.
- R7: During the pause, serial clock and data transitions change neither the bit position nor either shift register.
- R8: The pause ends when `holdN` is high while the serial clock is low, and `soOe` returns to 1. If `holdN` rises while the clock is high, the pause lasts through the next falling edge, and that edge is ignored.
- R9: Raising select during a pause ends the pause and aborts the transfer. The next transfer starts clean at bit 7 with no partial byte delivered.
- R10: After reset, `soOe`, `rxValid` and `txReady` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock from the master |
| siIn | input | 1 | Serial data from the master |
| csN | input | 1 | Active-low target select |
| holdN | input | 1 | Active-low transfer pause |
| soData | output | 1 | Serial data to the master |
| soOe | output | 1 | Output enable for soData; 0 means high impedance |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe: rxData updated |
| txData | input | 8 | Next byte to send |
| txReady | output | 1 | One-cycle strobe: present the next byte |

## Verification
The hardest case to reach is a pause whose edges fall in the clock's high phase. There, the entry falling edge must still shift the output, while the exit falling edge must be ignored. The bench reaches this by issuing, inside the bit loop of a transfer, a pause that starts and ends while the clock is high, with a garbage rising edge in between. It sweeps that position and an aligned pause position over every bit of a byte, in both idle polarities. Any lost or extra shift then shows up in both the received bytes and the bits sampled from the output line.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  // Strobes from control to datapath, one system cycle each
  typedef struct packed {
    logic capture;   // sample the data line into the receive shifter
    logic lastBit;   // this capture completes a byte
    logic loadTx;    // load txData into the transmit shifter
    logic shiftOut;  // advance the transmit shifter by one bit
  } dpStrobes_t;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckIn,
  input  logic       csNIn,
  input  logic       holdNIn,
  output dpStrobes_t strobes,
  output logic       soOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic sckS, csS, holdS;
  logic sckPrev, csPrev, holdActive, haveRise;
  logic [CNT_W-1:0] bitCnt;
  logic sckRise, sckFall, csStart;

  spi_hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncSck (
    .clk(clk), .rstN(rstN), .d(sckIn), .q(sckS));
  spi_hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncCs (
    .clk(clk), .rstN(rstN), .d(csNIn), .q(csS));
  spi_hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncHold (
    .clk(clk), .rstN(rstN), .d(holdNIn), .q(holdS));

  // Edges only count while selected and not paused (old pause state)
  assign sckRise = !csS && !holdActive && sckS && !sckPrev;
  assign sckFall = !csS && !holdActive && !sckS && sckPrev;
  assign csStart = csPrev && !csS;

  always_comb begin
    strobes.capture  = sckRise;
    strobes.lastBit  = sckRise && (bitCnt == LAST);
    strobes.loadTx   = csStart || (sckFall && haveRise && (bitCnt == '0));
    strobes.shiftOut = sckFall && haveRise && (bitCnt != '0);
  end

  assign soOe = !csS && !holdActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev    <= 1'b0;
      csPrev     <= 1'b1;
      holdActive <= 1'b0;
      haveRise   <= 1'b0;
      bitCnt     <= '0;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
      if (csS) begin
        holdActive <= 1'b0;
        haveRise   <= 1'b0;
        bitCnt     <= '0;
      end else begin
        // Pause state may only change during the clock's low phase
        if (!sckS) holdActive <= !holdS;
        if (sckRise) begin
          haveRise <= 1'b1;
          bitCnt   <= (bitCnt == LAST) ? '0 : bitCnt + CNT_W'(1);
        end else if (sckFall) begin
          haveRise <= 1'b0;
        end
      end
    end
  end

  // Deselect clears the bit position and the pause
  assert_deselect_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == '0) && !holdActive && !haveRise);
  // Pause only begins while the clock was low
  assert_entry_on_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> !$past(sckS));
  // Pause only ends on a low clock or on deselect
  assert_exit_on_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdActive) |-> (!$past(sckS) || $past(csS)));
  // Bit position frozen while paused
  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    (holdActive && !csS) |=> (bitCnt == $past(bitCnt)));
endmodule

// File: rtl/spi_hold_dp.sv
module spi_hold_dp
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              siIn,
  input  dpStrobes_t        strobes,
  input  logic [DATA_W-1:0] txData,
  output logic              soData,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txReady
);
  logic siS;
  logic [DATA_W-1:0] rxShift, txShift;

  // Same depth as the clock synchronizer keeps data aligned to edges
  spi_hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncSi (
    .clk(clk), .rstN(rstN), .d(siIn), .q(siS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
      txReady <= 1'b0;
    end else begin
      rxValid <= strobes.lastBit;
      txReady <= strobes.lastBit;
      if (strobes.capture) rxShift <= {rxShift[DATA_W-2:0], siS};
      if (strobes.lastBit) rxData <= {rxShift[DATA_W-2:0], siS};
      if (strobes.loadTx)        txShift <= txData;
      else if (strobes.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  assign soData = txShift[DATA_W-1];

  assert_one_cycle_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  assert_strobes_paired_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid == txReady);
  always_comb begin
    if (rstN) assert_load_shift_exclusive_R2: assert (!(strobes.loadTx && strobes.shiftOut));
  end
endmodule

// File: rtl/spi_hold_target.sv
module spi_hold_target
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              siIn,
  input  logic              csN,
  input  logic              holdN,
  output logic              soData,
  output logic              soOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady
);
  dpStrobes_t strobes;

  spi_hold_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csN), .holdNIn(holdN),
    .strobes(strobes), .soOe(soOe));

  spi_hold_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .siIn(siIn), .strobes(strobes), .txData(txData),
    .soData(soData), .rxData(rxData), .rxValid(rxValid), .txReady(txReady));
endmodule

// File: tb/spi_hold_target_bench.sv
module spi_hold_target_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, siIn = 1'b0, csN = 1'b1, holdN = 1'b1;
  logic soData, soOe, rxValid, txReady;
  logic [7:0] rxData, txData;

  always #4 clk = ~clk;  // 125 MHz

  spi_hold_target u_spi_hold_target (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .siIn(siIn), .csN(csN),
    .holdN(holdN), .soData(soData), .soOe(soOe), .rxData(rxData),
    .rxValid(rxValid), .txData(txData), .txReady(txReady));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] txBytes[0:3];
  logic [7:0] rxBytes[0:3];
  logic [7:0] rxGot[0:7];
  int rxCnt = 0, rdyCnt = 0, txIdx = 0;

  always_comb txData = (txIdx < 4) ? txBytes[txIdx] : 8'h00;

  always @(negedge clk) begin
    if (rxValid) begin
      if (rxCnt < 8) rxGot[rxCnt] = rxData;
      rxCnt = rxCnt + 1;
    end
    if (txReady) begin
      rdyCnt = rdyCnt + 1;
      txIdx = txIdx + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (6) @(posedge clk);
    #1;
  endtask

  // Aligned pause: inserted in the low phase of a bit
  task automatic alignedHold(input logic bitVal);
    holdN = 1'b0; waitH();
    chk(soOe == 1'b0, "R5 aligned entry", soOe, 0);
    sckIn = 1'b1; siIn = ~bitVal; waitH();
    sckIn = 1'b0; waitH();
    chk(soOe == 1'b0, "R7 toggles during pause", soOe, 0);
    siIn = bitVal;
    holdN = 1'b1; waitH();
    chk(soOe == 1'b1, "R8 aligned exit", soOe, 1);
  endtask

  // Misaligned pause: both edges in the high phase
  task automatic misHold(input logic bitVal);
    holdN = 1'b0; waitH();
    chk(soOe == 1'b1, "R6 entry deferred", soOe, 1);
    sckIn = 1'b0; waitH();
    chk(soOe == 1'b0, "R6 entry at low", soOe, 0);
    sckIn = 1'b1; siIn = ~bitVal; waitH();
    holdN = 1'b1; waitH();
    chk(soOe == 1'b0, "R8 exit deferred", soOe, 0);
  endtask

  task automatic runTxn(input int mode, input int nBytes, input int alignAt, input int misAt);
    bit pendExit = 1'b0;
    sckIn = (mode == 3); waitH();
    rxCnt = 0; rdyCnt = 0; txIdx = 0;
    csN = 1'b0;
    repeat (8) @(posedge clk);
    #1;
    for (int j = 0; j < nBytes; j++) begin
      logic [7:0] got = 8'h00;
      for (int b = 0; b < 8; b++) begin
        int gi = j * 8 + b;
        logic bitVal = rxBytes[j][7-b];
        sckIn = 1'b0; siIn = bitVal; waitH();
        if (pendExit) begin
          chk(soOe == 1'b1, "R8 exit after ignored fall", soOe, 1);
          pendExit = 1'b0;
        end
        if (gi == alignAt) alignedHold(bitVal);
        chk(soOe == 1'b1, "R2 output enabled", soOe, 1);
        got[7-b] = soData;
        sckIn = 1'b1; waitH();
        if (gi == misAt) begin
          misHold(bitVal);
          pendExit = 1'b1;
        end
      end
      chk(got == txBytes[j], "R2 sent byte", got, txBytes[j]);
    end
    if (mode == 0) begin sckIn = 1'b0; waitH(); end
    csN = 1'b1; waitH(); waitH();
    chk(soOe == 1'b0, "R4 deselect tri-state", soOe, 0);
    chk(rxCnt == nBytes, "R1 received count", rxCnt, nBytes);
    chk(rdyCnt == nBytes, "R3 ready pulses", rdyCnt, nBytes);
    for (int j = 0; j < nBytes && j < rxCnt; j++)
      chk(rxGot[j] == rxBytes[j], "R1 received byte", rxGot[j], rxBytes[j]);
  endtask

  task automatic setData(input int seed);
    for (int j = 0; j < 4; j++) begin
      rxBytes[j] = 8'((seed * 53 + j * 97 + 13) & 255);
      txBytes[j] = 8'((seed * 29 + j * 71 + 200) & 255);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    chk(soOe == 1'b0, "R10 reset soOe", soOe, 0);
    chk(rxValid == 1'b0, "R10 reset rxValid", rxValid, 0);
    chk(txReady == 1'b0, "R10 reset txReady", txReady, 0);
    rstN = 1'b1; waitH();

    // Plain transfers in both idle polarities
    for (int m = 0; m < 2; m++) begin
      setData(m + 1);
      runTxn(m * 3, 3, -1, -1);
    end
    // Sweep pause positions over every bit, both polarities
    for (int m = 0; m < 2; m++)
      for (int hp = 0; hp < 8; hp++) begin
        setData(hp * 7 + m + 3);
        runTxn(m * 3, 3, hp, 8 + hp);
      end

    // R4: abandoned partial byte, then a clean byte
    setData(40);
    sckIn = 1'b0; waitH();
    rxCnt = 0; rdyCnt = 0; txIdx = 0;
    csN = 1'b0; waitH();
    for (int b = 0; b < 5; b++) begin
      sckIn = 1'b0; siIn = 1'b1; waitH();
      sckIn = 1'b1; waitH();
    end
    sckIn = 1'b0; waitH();
    csN = 1'b1; waitH();
    chk(rxCnt == 0, "R4 no partial byte", rxCnt, 0);
    setData(41);
    runTxn(0, 1, -1, -1);

    // R9: deselect while paused
    setData(50);
    sckIn = 1'b0; waitH();
    rxCnt = 0; txIdx = 0;
    csN = 1'b0; waitH();
    for (int b = 0; b < 3; b++) begin
      sckIn = 1'b0; siIn = 1'b1; waitH();
      sckIn = 1'b1; waitH();
    end
    sckIn = 1'b0; holdN = 1'b0; waitH();
    chk(soOe == 1'b0, "R9 paused", soOe, 0);
    csN = 1'b1; waitH();
    chk(soOe == 1'b0, "R9 deselected in pause", soOe, 0);
    chk(rxCnt == 0, "R9 no partial byte", rxCnt, 0);
    holdN = 1'b1; waitH();
    setData(51);
    runTxn(3, 2, -1, -1);
    setData(52);
    runTxn(0, 2, 4, -1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule